// File: doc/BRIEF.md
# Serial Flash Catalog Record Fetcher

This block fetches one 16-byte catalog record from a serial flash and presents it as decoded fields. A single-cycle `start` pulse carries a 24-bit record address. If the address lies inside the catalog sector, the block selects the flash and runs a complete fast-read transaction over a mode-0 SPI link. The transaction is one command byte, three address bytes and one discarded dummy byte. Sixteen data bytes follow, and the block unpacks them into a name, a data address, a length and an info byte.

The flash is organised as sixteen 64 KB sectors. The configuration bitstream occupies sectors 0 to 4. The catalog is sector 5, at 0x50000 to 0x5FFFF, and sectors 6 to 15 hold user data. A request outside the catalog sector is refused without touching the flash. So is a record that would run past the end of the catalog sector.

Inside the block, the sequencer hands bytes to an SPI byte shifter over a valid/ready port. A byte is accepted only when valid and ready are both high in the same cycle. The shifter holds ready low for the whole of a byte, which holds off the sequencer until the byte is finished. Each received byte comes back as a single-cycle valid pulse with no ready: the sequencer always takes it in that cycle. The controls at the block's edge are plain pins with no handshake.

Top module: `catalog_fetcher`

## Requirements
- R1: After reset `spi_cs_n` is 1, `spi_sck` and `spi_mosi` are 0, `busy`, `done` and `err` are 0, and every field output is 0.
- R2: An accepted `start` drives `spi_cs_n` low on the next edge. It then sends the command byte 0x0B, followed by address bits 23:16, 15:8 and 7:0 in that order. Each byte goes out most significant bit first; `spi_mosi` is stable while `spi_sck` rises, and the flash samples it on the rising edge.
- R3: The fifth byte clocked in, the dummy byte, is discarded and never appears in any field.
- R4: While `spi_cs_n` is low, exactly 21 bytes (168 rising edges of `spi_sck`) are clocked. The last 16 of them are the record data, and `spi_cs_n` then returns high.
- R5: Record byte 0 lands in `name_o[79:72]` and byte 9 lands in `name_o[7:0]`. Bytes 10 to 12 form `data_addr_o` and bytes 13 to 14 form `length_o`, with the earlier byte more significant in each. Byte 15 is `info_o`.
- R6: `done` is high for exactly one cycle per fetch: the cycle after `spi_cs_n` returns high, with `busy` low in that cycle.
- R7: A `start` is accepted only when `rec_addr[23:16]` is 5 and `rec_addr[15:0]` is at most 0xFFF0. Any other address sets `err` on the next edge. In that case `spi_cs_n` stays high, `done` does not pulse and the fields keep their values. `err` holds until the next `start` in the idle state, and an accepted `start` clears it.
- R8: A `start` while `busy` is high is ignored: the running fetch completes unchanged.
- R9: Field outputs change only while `busy` is high, and they hold their values from `done` until the next accepted fetch.
- R10: `spi_sck` is low whenever `spi_cs_n` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Fetch request pulse |
| rec_addr | input | 24 | Flash address of the record |
| busy | output | 1 | Fetch in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Last request refused (address outside catalog) |
| name_o | output | 80 | Record name, first byte in the top bits |
| data_addr_o | output | 24 | Record data address |
| length_o | output | 16 | Record length |
| info_o | output | 8 | Record info byte |
| spi_cs_n | output | 1 | Flash chip select, active low |
| spi_sck | output | 1 | SPI clock, idle low |
| spi_mosi | output | 1 | Serial data to flash |
| spi_miso | input | 1 | Serial data from flash |

## Verification
A byte-index fault in the sequencer shows on the link within one byte time: a wrong command or address byte, or a 21-byte count off by one at chip-select release. A wrong store offset shows as fields shifted by one byte, for example the dummy value appearing in the top name byte, at the `done` pulse. A state machine that hangs or skips the release step is caught in the cycle concerned. In that case `done` arrives without a preceding rise of `spi_cs_n`, or it never arrives before the per-fetch timeout.

// File: rtl/catfetch_pkg.sv
package catfetch_pkg;
  localparam int          ADDR_W     = 24;
  localparam logic [7:0]  CMD_FREAD  = 8'h0B;
  localparam int          CMD_BYTES  = 1;
  localparam int          ADR_BYTES  = ADDR_W / 8;
  localparam int          DUMMY_BYTES = 1;
  localparam int          HDR_BYTES  = CMD_BYTES + ADR_BYTES + DUMMY_BYTES;
  localparam int          NAME_BYTES = 10;
  localparam int          DADR_BYTES = 3;
  localparam int          LEN_BYTES  = 2;
  localparam int          INFO_BYTES = 1;
  localparam int          REC_BYTES  = NAME_BYTES + DADR_BYTES + LEN_BYTES + INFO_BYTES;
  localparam int          DADR_OFS   = NAME_BYTES;
  localparam int          LEN_OFS    = DADR_OFS + DADR_BYTES;
  localparam int          INFO_OFS   = LEN_OFS + LEN_BYTES;
  localparam int          XFER_BYTES = HDR_BYTES + REC_BYTES;

  typedef enum logic [1:0] {
    SQ_IDLE,
    SQ_SEL,
    SQ_XFER,
    SQ_REL
  } seq_state_t;
endpackage

// File: rtl/spi_byte_shifter.sv
module spi_byte_shifter #(
  parameter int HALF_DIV = 1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tx_valid,
  output logic       tx_ready,
  input  logic [7:0] tx_byte,
  output logic       rx_valid,
  output logic [7:0] rx_byte,
  output logic       sck,
  output logic       mosi,
  input  logic       miso
);
  localparam int DIV_W = $clog2(HALF_DIV) + 1;

  logic             active;
  logic [DIV_W-1:0] div_cnt;
  logic [2:0]       bit_cnt;
  logic [7:0]       tx_sr;
  logic [7:0]       rx_sr;

  assign tx_ready = !active;
  assign mosi     = active & tx_sr[7];
  assign rx_byte  = rx_sr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active   <= 1'b0;
      div_cnt  <= '0;
      bit_cnt  <= '0;
      tx_sr    <= '0;
      rx_sr    <= '0;
      sck      <= 1'b0;
      rx_valid <= 1'b0;
    end else begin
      rx_valid <= 1'b0;
      if (!active) begin
        if (tx_valid) begin
          active  <= 1'b1;
          tx_sr   <= tx_byte;
          bit_cnt <= '0;
          div_cnt <= '0;
          sck     <= 1'b0;
        end
      end else if (div_cnt == DIV_W'(HALF_DIV - 1)) begin
        div_cnt <= '0;
        if (!sck) begin
          sck   <= 1'b1;
          rx_sr <= {rx_sr[6:0], miso};
        end else begin
          sck     <= 1'b0;
          tx_sr   <= {tx_sr[6:0], 1'b0};
          bit_cnt <= bit_cnt + 3'd1;
          if (bit_cnt == 3'd7) begin
            active   <= 1'b0;
            rx_valid <= 1'b1;
          end
        end
      end else begin
        div_cnt <= div_cnt + DIV_W'(1);
      end
    end
  end
endmodule

// File: rtl/fetch_sequencer.sv
module fetch_sequencer
  import catfetch_pkg::*;
#(
  parameter logic [7:0] CAT_SECTOR = 8'h05
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] rec_addr,
  output logic              busy,
  output logic              done,
  output logic              err,
  output logic              cs_n,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic [7:0]        tx_byte,
  input  logic              rx_valid,
  output logic              wr_en,
  output logic [$clog2(REC_BYTES)-1:0] wr_idx
);
  localparam int IDX_W = $clog2(XFER_BYTES + 1);
  localparam int RIX_W = $clog2(REC_BYTES);
  localparam logic [15:0] LAST_OFS = 16'(16'hFFFF - (REC_BYTES - 1));

  seq_state_t        state;
  logic [IDX_W-1:0]  idx;
  logic              pending;
  logic [ADDR_W-1:0] addr_q;
  logic              addr_ok;

  assign addr_ok  = (rec_addr[23:16] == CAT_SECTOR) && (rec_addr[15:0] <= LAST_OFS);
  assign busy     = (state != SQ_IDLE);
  assign tx_valid = (state == SQ_XFER) && !pending;
  assign wr_en    = (state == SQ_XFER) && rx_valid && (idx >= IDX_W'(HDR_BYTES));
  assign wr_idx   = RIX_W'(idx - IDX_W'(HDR_BYTES));

  always_comb begin
    case (idx)
      IDX_W'(0): tx_byte = CMD_FREAD;
      IDX_W'(1): tx_byte = addr_q[23:16];
      IDX_W'(2): tx_byte = addr_q[15:8];
      IDX_W'(3): tx_byte = addr_q[7:0];
      default:   tx_byte = 8'h00;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= SQ_IDLE;
      idx     <= '0;
      pending <= 1'b0;
      addr_q  <= '0;
      cs_n    <= 1'b1;
      done    <= 1'b0;
      err     <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        SQ_IDLE: if (start) begin
          err <= !addr_ok;
          if (addr_ok) begin
            state   <= SQ_SEL;
            cs_n    <= 1'b0;
            addr_q  <= rec_addr;
            idx     <= '0;
            pending <= 1'b0;
          end
        end
        SQ_SEL: state <= SQ_XFER;
        SQ_XFER: begin
          if (tx_valid && tx_ready) pending <= 1'b1;
          if (rx_valid) begin
            pending <= 1'b0;
            if (idx == IDX_W'(XFER_BYTES - 1)) begin
              state <= SQ_REL;
              cs_n  <= 1'b1;
            end else begin
              idx <= idx + IDX_W'(1);
            end
          end
        end
        default: begin
          state <= SQ_IDLE;
          done  <= 1'b1;
        end
      endcase
    end
  end
endmodule

// File: rtl/record_store.sv
module record_store
  import catfetch_pkg::*;
(
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wr_en,
  input  logic [$clog2(REC_BYTES)-1:0] wr_idx,
  input  logic [7:0]                   wr_data,
  output logic [NAME_BYTES*8-1:0]      name_o,
  output logic [DADR_BYTES*8-1:0]      data_addr_o,
  output logic [LEN_BYTES*8-1:0]       length_o,
  output logic [INFO_BYTES*8-1:0]      info_o
);
  logic [7:0] rec [REC_BYTES];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < REC_BYTES; i++) rec[i] <= '0;
    end else if (wr_en) begin
      rec[wr_idx] <= wr_data;
    end
  end

  for (genvar i = 0; i < NAME_BYTES; i++) begin : g_name
    assign name_o[(NAME_BYTES-1-i)*8 +: 8] = rec[i];
  end
  for (genvar i = 0; i < DADR_BYTES; i++) begin : g_dadr
    assign data_addr_o[(DADR_BYTES-1-i)*8 +: 8] = rec[DADR_OFS+i];
  end
  for (genvar i = 0; i < LEN_BYTES; i++) begin : g_len
    assign length_o[(LEN_BYTES-1-i)*8 +: 8] = rec[LEN_OFS+i];
  end
  for (genvar i = 0; i < INFO_BYTES; i++) begin : g_info
    assign info_o[(INFO_BYTES-1-i)*8 +: 8] = rec[INFO_OFS+i];
  end
endmodule

// File: rtl/catalog_fetcher.sv
module catalog_fetcher
  import catfetch_pkg::*;
#(
  parameter int         HALF_DIV   = 1,
  parameter logic [7:0] CAT_SECTOR = 8'h05
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start,
  input  logic [ADDR_W-1:0]       rec_addr,
  output logic                    busy,
  output logic                    done,
  output logic                    err,
  output logic [NAME_BYTES*8-1:0] name_o,
  output logic [DADR_BYTES*8-1:0] data_addr_o,
  output logic [LEN_BYTES*8-1:0]  length_o,
  output logic [INFO_BYTES*8-1:0] info_o,
  output logic                    spi_cs_n,
  output logic                    spi_sck,
  output logic                    spi_mosi,
  input  logic                    spi_miso
);
  logic       tx_valid, tx_ready, rx_valid, wr_en;
  logic [7:0] tx_byte, rx_byte;
  logic [$clog2(REC_BYTES)-1:0] wr_idx;

  fetch_sequencer #(.CAT_SECTOR(CAT_SECTOR)) seq_i (
    .clk(clk), .rst_n(rst_n), .start(start), .rec_addr(rec_addr),
    .busy(busy), .done(done), .err(err), .cs_n(spi_cs_n),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_byte(tx_byte),
    .rx_valid(rx_valid), .wr_en(wr_en), .wr_idx(wr_idx)
  );

  spi_byte_shifter #(.HALF_DIV(HALF_DIV)) shf_i (
    .clk(clk), .rst_n(rst_n), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .tx_byte(tx_byte), .rx_valid(rx_valid), .rx_byte(rx_byte),
    .sck(spi_sck), .mosi(spi_mosi), .miso(spi_miso)
  );

  record_store rec_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_data(rx_byte), .name_o(name_o), .data_addr_o(data_addr_o),
    .length_o(length_o), .info_o(info_o)
  );
endmodule

// File: rtl/catalog_fetcher_chk.sv
module catalog_fetcher_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        start,
  input logic [23:0] rec_addr,
  input logic        busy,
  input logic        done,
  input logic        err,
  input logic [79:0] name_o,
  input logic [23:0] data_addr_o,
  input logic [15:0] length_o,
  input logic [7:0]  info_o,
  input logic        spi_cs_n,
  input logic        spi_sck,
  input logic        spi_mosi,
  input logic        spi_miso
);
  logic bad_addr;
  assign bad_addr = (rec_addr[23:16] != 8'h05) || (rec_addr[15:0] > 16'hFFF0);

  assert_sck_low_deselected_R10: assert property (@(posedge clk) disable iff (!rst_n)
    spi_cs_n |-> !spi_sck);

  assert_done_after_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(spi_cs_n) |=> (done && !busy));

  assert_done_needs_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (spi_cs_n && $past(spi_cs_n) && !$past(done)));

  assert_reject_no_select_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && bad_addr) |=> (err && spi_cs_n && !busy));

  assert_select_needs_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(spi_cs_n) |-> ($past(start) && !$past(busy)));

  assert_fields_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !$past(busy)) |-> ($stable(name_o) && $stable(data_addr_o)
                                 && $stable(length_o) && $stable(info_o)));
endmodule

bind catalog_fetcher catalog_fetcher_chk chk_i (.*);

// File: tb/catalog_fetcher_tb_top.sv
`timescale 1ns/1ps
module catalog_fetcher_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [23:0] rec_addr = '0;
  logic busy, done, err, spi_cs_n, spi_sck, spi_mosi;
  logic spi_miso = 1'b0;
  logic [79:0] name_o;
  logic [23:0] data_addr_o;
  logic [15:0] length_o;
  logic [7:0]  info_o;

  always #5 clk = ~clk;

  catalog_fetcher dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .rec_addr(rec_addr),
    .busy(busy), .done(done), .err(err), .name_o(name_o),
    .data_addr_o(data_addr_o), .length_o(length_o), .info_o(info_o),
    .spi_cs_n(spi_cs_n), .spi_sck(spi_sck), .spi_mosi(spi_mosi),
    .spi_miso(spi_miso)
  );

  int total = 0;
  int bad = 0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // flash contents model
  function automatic logic [7:0] fbyte(input logic [23:0] a);
    return a[7:0] ^ {a[11:8], a[19:16]} ^ 8'h5A;
  endfunction

  logic [23:0] flash_base = '0;
  int          nbit = 0;
  int          rises = 0;
  logic [7:0]  sh_in = '0;
  logic [7:0]  mosi_q[$];

  function automatic logic resp_bit(input int n);
    int k;
    logic [7:0] b;
    k = n / 8;
    if (k < 4) b = 8'h00;
    else if (k == 4) b = 8'hC3;
    else b = fbyte(flash_base + 24'(k - 5));
    return b[7 - (n % 8)];
  endfunction

  initial forever begin
    @(negedge spi_cs_n);
    nbit = 0;
    spi_miso = resp_bit(0);
  end
  initial forever begin
    @(posedge spi_sck);
    sh_in = {sh_in[6:0], spi_mosi};
    nbit++;
    rises++;
    if (nbit % 8 == 0) mosi_q.push_back(sh_in);
  end
  initial forever begin
    @(negedge spi_sck);
    if (!spi_cs_n) spi_miso = resp_bit(nbit);
  end

  // per-clock monitor: done timing and idle clock (R6, R10)
  int   done_cnt = 0;
  int   mon_bad = 0;
  logic cs_p1 = 1'b1, cs_p2 = 1'b1;
  initial forever begin
    @(negedge clk);
    if (rst_n) begin
      if (spi_cs_n && spi_sck) mon_bad++;
      if (done) begin
        done_cnt++;
        if (!(cs_p1 && !cs_p2 && spi_cs_n && !busy)) mon_bad++;
      end
    end
    cs_p2 = cs_p1;
    cs_p1 = spi_cs_n;
  end

  task automatic pulse_start(input logic [23:0] a);
    @(negedge clk);
    start = 1'b1;
    rec_addr = a;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic fetch_ok(input logic [23:0] a, input bit intrude);
    int d0, r0, w;
    logic [79:0] en;
    d0 = done_cnt;
    flash_base = a;
    mosi_q.delete();
    r0 = rises;
    pulse_start(a);
    chk(!spi_cs_n && busy, "R2 select after start", spi_cs_n, 0);
    if (intrude) begin
      repeat (100) @(negedge clk);
      pulse_start(24'h058000);
    end
    w = 0;
    while (done_cnt == d0 && w < 2000) begin
      @(negedge clk);
      w++;
    end
    chk(w < 2000, "R6 done arrives", w, 0);
    chk(done_cnt == d0 + 1, "R6 single done", done_cnt - d0, 1);
    chk(rises - r0 == 168 && mosi_q.size() == 21, "R4 byte count", rises - r0, 168);
    if (mosi_q.size() >= 4) begin
      chk(mosi_q[0] == 8'h0B, "R2 command", mosi_q[0], 8'h0B);
      chk({mosi_q[1], mosi_q[2], mosi_q[3]} == a, "R2 address",
          {mosi_q[1], mosi_q[2], mosi_q[3]}, a);
    end
    en = '0;
    for (int i = 0; i < 10; i++) en[(9-i)*8 +: 8] = fbyte(a + 24'(i));
    chk(name_o[79:72] == fbyte(a), "R3 dummy discarded", name_o[79:72], fbyte(a));
    chk(name_o == en, "R5 name", name_o, en);
    chk(data_addr_o == {fbyte(a+24'd10), fbyte(a+24'd11), fbyte(a+24'd12)}, "R5 data addr",
        data_addr_o, {fbyte(a+24'd10), fbyte(a+24'd11), fbyte(a+24'd12)});
    chk(length_o == {fbyte(a+24'd13), fbyte(a+24'd14)}, "R5 length",
        length_o, {fbyte(a+24'd13), fbyte(a+24'd14)});
    chk(info_o == fbyte(a+24'd15), "R5 info", info_o, fbyte(a+24'd15));
    chk(!err && !busy, "R7 err clear after accepted fetch", err, 0);
  endtask

  task automatic fetch_bad(input logic [23:0] a);
    int d0, r0;
    logic [79:0] n0;
    logic [7:0]  i0;
    d0 = done_cnt;
    r0 = rises;
    n0 = name_o;
    i0 = info_o;
    pulse_start(a);
    chk(err && spi_cs_n && !busy, "R7 reject flags", err, 1);
    repeat (40) @(negedge clk);
    chk(rises == r0 && spi_cs_n, "R7 no transaction", rises - r0, 0);
    chk(done_cnt == d0, "R7 no done", done_cnt - d0, 0);
    chk(name_o == n0 && info_o == i0, "R7 R9 fields kept", name_o, n0);
    chk(err, "R7 err holds", err, 1);
  endtask

  initial begin
    #(10 * 200000);
    bad++;
    total++;
    $display("FAIL watchdog expired R4 actual=hung expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [79:0] hn;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(spi_cs_n && !spi_sck && !spi_mosi, "R1 link idle", {spi_cs_n, spi_sck, spi_mosi}, 3'b100);
    chk(!busy && !done && !err, "R1 status idle", {busy, done, err}, 0);
    chk(name_o == '0 && data_addr_o == '0 && length_o == '0 && info_o == '0,
        "R1 fields zero", name_o, 0);

    fetch_ok(24'h050000, 1'b0);
    fetch_ok(24'h05FFF0, 1'b0);
    fetch_bad(24'h05FFF1);
    fetch_bad(24'h040000);
    fetch_bad(24'h060000);
    fetch_ok(24'h05ABCD, 1'b0);
    fetch_ok(24'h051234, 1'b1);   // R8: start during busy ignored

    hn = name_o;
    repeat (50) @(negedge clk);
    chk(name_o == hn && !busy, "R9 hold between fetches", name_o, hn);
    chk(mon_bad == 0, "R6 R10 per-clock monitor", mon_bad, 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule